// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Generation

This block is the purely combinational arithmetic and logic stage of a small accumulator-based microcontroller. In the same cycle it takes the accumulator value, a second operand (a data-memory byte or an immediate), the current carry and auxiliary-carry flags and a 5-bit operation code. It returns an 8-bit result, new carry, auxiliary-carry, zero and overflow values, an update mask that tells the status register which of those four flags the operation writes, and a skip decision for the conditional test-and-skip operations.

The block holds no state. Instruction decode, register file access, the program counter and the status register all sit outside it. Unary operations (complement, rotates, increment, decrement and the skip tests) act on the second operand `b_i`. Decimal adjust acts on the accumulator `a_i`. Subtraction is carried out as an addition of the inverted operand, so a carry of 1 after a subtraction means that no borrow occurred.

Top module: `acc_alu`

## Requirements
- R1: Opcodes are ADD=0, ADC=1, SUB=2, SBC=3, DAA=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RR=10, RLC=11, RRC=12, INC=13, DEC=14, SZ=15, SNZ=16, SIZ=17, SDZ=18. ADD returns (a+b) mod 256 and ADC returns (a+b+c_i) mod 256. In both, the carry output is bit 8 of the full sum.
- R2: SUB returns (a + ~b + 1) mod 256 and SBC returns (a + ~b + c_i) mod 256. The carry output is bit 8 of that sum, so 1 means no borrow.
- R3: For the four add/subtract operations, the auxiliary carry is the carry out of the low-nibble addition of the same operands, including the carry in.
- R4: For the four add/subtract operations, overflow is the carry into bit 7 XOR the carry out of bit 7. This equals a signed overflow of the addend pair.
- R5: For the add/subtract, logic, INC and DEC operations, the zero output is 1 exactly when the 8-bit result is 0.
- R6: AND, OR and XOR combine a and b, and CPL returns ~b. These operations write only the zero flag.
- R7: RL and RR rotate b left or right by one bit without using the carry, and they write no flag.
- R8: RLC and RRC rotate b through c_i (9-bit rotation). The new carry is the bit shifted out, and only the carry flag is written.
- R9: INC returns (b+1) mod 256 and DEC returns (b−1) mod 256. Both write only the zero flag.
- R10: DAA adds 0x06 if a[3:0]>9 or ac_i=1, and adds 0x60 if a[7:4]>9 or c_i=1. Both conditions are judged on the unadjusted a. The new carry is c_i OR the carry out of that addition, and only the carry flag is written.
- R11: The skip output is 1 for SZ when b=0, for SNZ when b≠0, for SIZ when (b+1) mod 256=0, and for SDZ when (b−1) mod 256=0. The result of SZ/SNZ is b, and the result of SIZ/SDZ is the incremented or decremented value. None of these four writes a flag, and no other operation raises skip.
- R12: The update mask bits are [0]=carry, [1]=aux carry, [2]=zero, [3]=overflow, and add/subtract sets all four. Any flag output whose mask bit is 0 reads 0. Opcodes 19–31 return a unchanged, with mask 0 and skip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand (memory byte or immediate) |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| op_i | input | 5 | Operation code |
| res_o | output | 8 | Operation result |
| c_o | output | 1 | New carry value |
| ac_o | output | 1 | New auxiliary carry value |
| z_o | output | 1 | New zero value |
| ov_o | output | 1 | New overflow value |
| upd_o | output | 4 | Flag update mask |
| skip_o | output | 1 | Skip decision for test-and-skip operations |

## Verification
The cases that are hardest to hit are the low-nibble borrow under SBC and the signed overflow. Each needs a specific pairing of nibble values with the incoming carry, and the decimal-adjust corner where an incoming carry forces the high correction even though no new carry-out occurs. To reach them, every arithmetic and logic operation is swept over all 256 accumulator values against 32 second-operand values that spread across the byte and include 0x00 and 0xFF, with both carry-in values. Unary and skip operations sweep all 256 operand values. DAA sweeps every accumulator value against all four carry/auxiliary-carry combinations, and every reserved opcode is probed.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 5;
    localparam int FLAG_N = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBC = 5'd3,
        OP_DAA = 5'd4,
        OP_AND = 5'd5,
        OP_OR  = 5'd6,
        OP_XOR = 5'd7,
        OP_CPL = 5'd8,
        OP_RL  = 5'd9,
        OP_RR  = 5'd10,
        OP_RLC = 5'd11,
        OP_RRC = 5'd12,
        OP_INC = 5'd13,
        OP_DEC = 5'd14,
        OP_SZ  = 5'd15,
        OP_SNZ = 5'd16,
        OP_SIZ = 5'd17,
        OP_SDZ = 5'd18
    } alu_op_e;

    typedef enum logic [2:0] {
        SRC_A,
        SRC_B,
        SRC_ADD,
        SRC_BIT,
        SRC_DEC
    } res_src_e;

    typedef enum logic [2:0] {
        SKP_NONE,
        SKP_B_ZERO,
        SKP_B_NONZERO,
        SKP_SUM_ZERO
    } skip_kind_e;

    localparam int F_C  = 0;
    localparam int F_AC = 1;
    localparam int F_Z  = 2;
    localparam int F_OV = 3;

    localparam logic [FLAG_N-1:0] UPD_NONE = 4'b0000;
    localparam logic [FLAG_N-1:0] UPD_C    = 4'b0001;
    localparam logic [FLAG_N-1:0] UPD_Z    = 4'b0100;
    localparam logic [FLAG_N-1:0] UPD_ALL  = 4'b1111;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         nib_c_o,
    output logic         msb_cin_o,
    output logic         c_o
);
    localparam int MW = W - 1 - NW;

    logic [NW:0] lo_part;
    logic [MW:0] mid_part;
    logic [1:0]  top_part;

    always_comb begin
        lo_part  = {1'b0, x_i[NW-1:0]} + {1'b0, y_i[NW-1:0]} + (NW+1)'(cin_i);
        mid_part = {1'b0, x_i[W-2:NW]} + {1'b0, y_i[W-2:NW]} + (MW+1)'(lo_part[NW]);
        top_part = {1'b0, x_i[W-1]} + {1'b0, y_i[W-1]} + 2'(mid_part[MW]);
    end

    assign sum_o     = {top_part[0], mid_part[MW-1:0], lo_part[NW-1:0]};
    assign nib_c_o   = lo_part[NW];
    assign msb_cin_o = mid_part[MW];
    assign c_o       = top_part[1];

    // R1 / R2: the segmented carry chain must agree with a single wide add
    logic [W:0] whole_sum;
    always_comb begin
        whole_sum = {1'b0, x_i} + {1'b0, y_i} + (W+1)'(cin_i);
        a_r1_chain_matches_wide_add: assert (whole_sum == {c_o, sum_o})
            else $error("R1 chain sum mismatch");
    end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    always_comb begin
        res_o = b_i;
        c_o   = c_i;
        case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CPL: res_o = ~b_i;
            OP_RL:  res_o = {b_i[W-2:0], b_i[W-1]};
            OP_RR:  res_o = {b_i[0], b_i[W-1:1]};
            OP_RLC: begin
                res_o = {b_i[W-2:0], c_i};
                c_o   = b_i[W-1];
            end
            OP_RRC: begin
                res_o = {c_i, b_i[W-1:1]};
                c_o   = b_i[0];
            end
            default: res_o = b_i;
        endcase
    end

    always_comb begin
        // R7: a plain rotate neither gains nor loses set bits
        if (op_i == OP_RL || op_i == OP_RR) begin
            a_r7_rotate_keeps_ones: assert ($countones(res_o) == $countones(b_i))
                else $error("R7 rotate changed bit count");
        end
        // R8: rotation through carry conserves the nine-bit population
        if (op_i == OP_RLC || op_i == OP_RRC) begin
            a_r8_carry_rotate_conserves: assert (($countones(res_o) + 32'(c_o)) ==
                                                 ($countones(b_i) + 32'(c_i)))
                else $error("R8 carry rotate lost a bit");
        end
    end

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
    parameter int W  = 8,
    parameter int NW = 4
) (
    input  logic [W-1:0] a_i,
    input  logic         c_i,
    input  logic         ac_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
    localparam logic [W-1:0]  LO_FIX    = W'(6);
    localparam logic [W-1:0]  HI_FIX    = W'(6) << NW;

    logic         fix_lo;
    logic         fix_hi;
    logic [W-1:0] adj;
    logic [W:0]   adj_sum;

    always_comb begin
        fix_lo  = (a_i[NW-1:0] > DIGIT_MAX) || ac_i;
        fix_hi  = (a_i[W-1:NW] > DIGIT_MAX) || c_i;
        adj     = (fix_lo ? LO_FIX : '0) | (fix_hi ? HI_FIX : '0);
        adj_sum = {1'b0, a_i} + {1'b0, adj};
    end

    assign res_o = adj_sum[W-1:0];
    assign c_o   = c_i | adj_sum[W];

    // R10: the result moves away from a only by one of the four correction steps
    logic [W-1:0] step;
    always_comb begin
        step = res_o - a_i;
        a_r10_adjust_step_legal: assert (step == '0 || step == LO_FIX ||
                                         step == HI_FIX || step == (LO_FIX | HI_FIX))
            else $error("R10 illegal decimal correction");
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic       c_i,
    input  logic       ac_i,
    input  logic [4:0] op_i,
    output logic [7:0] res_o,
    output logic       c_o,
    output logic       ac_o,
    output logic       z_o,
    output logic       ov_o,
    output logic [3:0] upd_o,
    output logic       skip_o
);
    alu_op_e    op;
    res_src_e   sel;
    skip_kind_e skip_kind;

    logic [DATA_W-1:0] add_x, add_y, add_sum, bit_res, dec_res;
    logic              add_cin, add_nib_c, add_msb_cin, add_c;
    logic              bit_c, dec_c;
    logic [FLAG_N-1:0] mask;
    logic              c_raw;

    assign op = alu_op_e'(op_i);

    // operation decode: adder operands, result source, flag mask, skip kind
    always_comb begin
        add_x     = a_i;
        add_y     = b_i;
        add_cin   = 1'b0;
        sel       = SRC_A;
        mask      = UPD_NONE;
        skip_kind = SKP_NONE;
        unique case (op)
            OP_ADD: begin sel = SRC_ADD; mask = UPD_ALL; end
            OP_ADC: begin sel = SRC_ADD; mask = UPD_ALL; add_cin = c_i; end
            OP_SUB: begin sel = SRC_ADD; mask = UPD_ALL; add_y = ~b_i; add_cin = 1'b1; end
            OP_SBC: begin sel = SRC_ADD; mask = UPD_ALL; add_y = ~b_i; add_cin = c_i; end
            OP_DAA: begin sel = SRC_DEC; mask = UPD_C; end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin sel = SRC_BIT; mask = UPD_Z; end
            OP_RL, OP_RR:   sel = SRC_BIT;
            OP_RLC, OP_RRC: begin sel = SRC_BIT; mask = UPD_C; end
            OP_INC: begin
                sel = SRC_ADD; mask = UPD_Z;
                add_x = b_i; add_y = '0; add_cin = 1'b1;
            end
            OP_DEC: begin
                sel = SRC_ADD; mask = UPD_Z;
                add_x = b_i; add_y = '1; add_cin = 1'b0;
            end
            OP_SZ:  begin sel = SRC_B; skip_kind = SKP_B_ZERO; end
            OP_SNZ: begin sel = SRC_B; skip_kind = SKP_B_NONZERO; end
            OP_SIZ: begin
                sel = SRC_ADD; skip_kind = SKP_SUM_ZERO;
                add_x = b_i; add_y = '0; add_cin = 1'b1;
            end
            OP_SDZ: begin
                sel = SRC_ADD; skip_kind = SKP_SUM_ZERO;
                add_x = b_i; add_y = '1; add_cin = 1'b0;
            end
            default: begin sel = SRC_A; mask = UPD_NONE; end
        endcase
    end

    acc_alu_adder #(.W(DATA_W), .NW(NIB_W)) adder_i (
        .x_i       (add_x),
        .y_i       (add_y),
        .cin_i     (add_cin),
        .sum_o     (add_sum),
        .nib_c_o   (add_nib_c),
        .msb_cin_o (add_msb_cin),
        .c_o       (add_c)
    );

    acc_alu_bitops #(.W(DATA_W)) bitops_i (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .c_i   (c_i),
        .res_o (bit_res),
        .c_o   (bit_c)
    );

    acc_alu_decadj #(.W(DATA_W), .NW(NIB_W)) decadj_i (
        .a_i   (a_i),
        .c_i   (c_i),
        .ac_i  (ac_i),
        .res_o (dec_res),
        .c_o   (dec_c)
    );

    // result and raw carry selection
    always_comb begin
        unique case (sel)
            SRC_ADD: begin res_o = add_sum; c_raw = add_c; end
            SRC_BIT: begin res_o = bit_res; c_raw = bit_c; end
            SRC_DEC: begin res_o = dec_res; c_raw = dec_c; end
            SRC_B:   begin res_o = b_i;     c_raw = c_i;   end
            default: begin res_o = a_i;     c_raw = c_i;   end
        endcase
    end

    // skip decision
    always_comb begin
        unique case (skip_kind)
            SKP_B_ZERO:    skip_o = (b_i == '0);
            SKP_B_NONZERO: skip_o = (b_i != '0);
            SKP_SUM_ZERO:  skip_o = (add_sum == '0);
            default:       skip_o = 1'b0;
        endcase
    end

    // masked flag outputs
    assign upd_o = mask;
    assign c_o   = mask[F_C]  & c_raw;
    assign ac_o  = mask[F_AC] & add_nib_c;
    assign z_o   = mask[F_Z]  & (res_o == '0);
    assign ov_o  = mask[F_OV] & (add_msb_cin ^ add_c);

    always_comb begin
        // R4: an addition overflow needs like-signed operands and a sign flip
        if ((op == OP_ADD || op == OP_ADC) && ov_o) begin
            a_r4_ov_sign_flip: assert (a_i[DATA_W-1] == b_i[DATA_W-1] &&
                                       res_o[DATA_W-1] != a_i[DATA_W-1])
                else $error("R4 overflow without sign flip");
        end
        // R5: a reported zero flag always comes with a zero result
        if (z_o) begin
            a_r5_zero_means_zero: assert (res_o == '0)
                else $error("R5 zero flag on nonzero result");
        end
        // R11: only the four test operations may request a skip
        if (skip_o) begin
            a_r11_skip_only_tests: assert (op_i >= OP_SZ && op_i <= OP_SDZ && upd_o == UPD_NONE)
                else $error("R11 skip from non-test op");
        end
        // R12: reserved codes pass the accumulator and stay quiet
        if (op_i > OP_SDZ) begin
            a_r12_reserved_quiet: assert (upd_o == UPD_NONE && !skip_o && res_o == a_i &&
                                          !c_o && !ac_o && !z_o && !ov_o)
                else $error("R12 reserved opcode not quiet");
        end
    end

endmodule

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0] a = 8'd0, b = 8'd0;
    logic       cin = 1'b0, acin = 1'b0;
    logic [4:0] op = 5'd0;
    logic [7:0] res;
    logic       c, ac, z, ov, skip;
    logic [3:0] upd;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    acc_alu dut_i (
        .a_i(a), .b_i(b), .c_i(cin), .ac_i(acin), .op_i(op),
        .res_o(res), .c_o(c), .ac_o(ac), .z_o(z), .ov_o(ov),
        .upd_o(upd), .skip_o(skip)
    );

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (op=%0d a=%0h b=%0h c=%0d ac=%0d)",
                     req, act, exp, op, a, b, cin, acin);
        end
    endtask

    // packs res[16:9] c ac z ov mask[4:1] skip
    function automatic int pack(input int r, input int fc, input int fac, input int fz,
                                input int fov, input int m, input int s);
        return (r << 9) | (fc << 8) | (fac << 7) | (fz << 6) | (fov << 5) | (m << 1) | s;
    endfunction

    task automatic model(input int o, input int av, input int bv, input int cv, input int acv,
                         output int r, output int fc, output int fac, output int fz,
                         output int fov, output int m, output int s);
        int bb, ci, sum, adj, t;
        r = av; fc = 0; fac = 0; fz = 0; fov = 0; m = 0; s = 0;
        case (o)
            0, 1, 2, 3: begin
                bb  = (o >= 2) ? (255 - bv) : bv;
                ci  = (o == 0) ? 0 : (o == 2) ? 1 : cv;
                sum = av + bb + ci;
                r   = sum % 256;
                fc  = sum / 256;
                fac = ((av % 16) + (bb % 16) + ci) / 16;
                fov = ((av / 128) == (bb / 128) && (r / 128) != (av / 128)) ? 1 : 0;
                fz  = (r == 0);
                m   = 15;
            end
            4: begin
                adj = 0;
                if ((av % 16) > 9 || acv != 0) adj += 6;
                if ((av / 16) > 9 || cv != 0)  adj += 96;
                t  = av + adj;
                r  = t % 256;
                fc = (cv != 0 || t >= 256) ? 1 : 0;
                m  = 1;
            end
            5:  begin r = av & bv;   m = 4; fz = (r == 0); end
            6:  begin r = av | bv;   m = 4; fz = (r == 0); end
            7:  begin r = av ^ bv;   m = 4; fz = (r == 0); end
            8:  begin r = 255 - bv;  m = 4; fz = (r == 0); end
            9:  r = ((bv * 2) % 256) + (bv / 128);
            10: r = (bv / 2) + ((bv % 2) * 128);
            11: begin r = ((bv * 2) % 256) + cv; fc = bv / 128; m = 1; end
            12: begin r = (bv / 2) + cv * 128;   fc = bv % 2;   m = 1; end
            13: begin r = (bv + 1) % 256;   m = 4; fz = (r == 0); end
            14: begin r = (bv + 255) % 256; m = 4; fz = (r == 0); end
            15: begin r = bv; s = (bv == 0); end
            16: begin r = bv; s = (bv != 0); end
            17: begin r = (bv + 1) % 256;   s = (r == 0); end
            18: begin r = (bv + 255) % 256; s = (r == 0); end
            default: r = av;
        endcase
    endtask

    function automatic string req_of(input int o);
        case (o)
            4:             return "R10";
            5, 6, 7, 8:    return "R6";
            9, 10:         return "R7";
            11, 12:        return "R8";
            13, 14:        return "R9";
            15, 16, 17, 18: return "R11";
            default:       return "R12";
        endcase
    endfunction

    task automatic run_vec(input int o, input int av, input int bv, input int cv, input int acv);
        int r, fc, fac, fz, fov, m, s;
        op = 5'(o); a = 8'(av); b = 8'(bv); cin = 1'(cv); acin = 1'(acv);
        #2;
        model(o, av, bv, cv, acv, r, fc, fac, fz, fov, m, s);
        if (o <= 3) begin
            check((o <= 1) ? "R1" : "R2", {23'd0, res, c}, (r << 1) | fc);
            check("R3", int'(ac), fac);
            check("R4", int'(ov), fov);
            check("R5", int'(z), fz);
            check("R12", {27'd0, upd, skip}, (m << 1) | s);
        end else begin
            check(req_of(o), int'({res, c, ac, z, ov, upd, skip}),
                  pack(r, fc, fac, fz, fov, m, s));
        end
        #2;
    endtask

    initial begin : watchdog
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_bad++;
                n_total++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                $display("  test done: total=%0d bad=%0d", n_total, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // quiet state with all-zero inputs: ADD of zeros, zero flag set (R5, R12)
        check("R12", int'({res, c, ac, z, ov, upd, skip}), pack(0, 0, 0, 1, 0, 15, 0));

        // R1 R2 R3 R4 R5 R6: two-operand sweep
        for (int o = 0; o <= 7; o++) begin
            if (o == 4) continue;
            for (int av = 0; av < 256; av++) begin
                for (int j = 0; j < 32; j++) begin
                    for (int cv = 0; cv < 2; cv++) begin
                        if (o >= 5 && cv == 1) continue;
                        run_vec(o, av, (j * 8) | (j % 8), cv, 0);
                    end
                end
            end
        end

        // R6 R7 R8 R9 R11: unary ops over every operand value
        for (int o = 8; o <= 18; o++) begin
            for (int bv = 0; bv < 256; bv++) begin
                for (int cv = 0; cv < 2; cv++) begin
                    run_vec(o, (bv * 37) % 256, bv, cv, 1 - cv);
                end
            end
        end

        // R10: decimal adjust over every accumulator and flag pair
        for (int av = 0; av < 256; av++) begin
            for (int fl = 0; fl < 4; fl++) begin
                run_vec(4, av, 255 - av, fl % 2, fl / 2);
            end
        end

        // R12: reserved opcodes leave a unchanged and write nothing
        for (int o = 19; o < 32; o++) begin
            for (int k = 0; k < 8; k++) begin
                run_vec(o, k * 33, 255 - k * 17, k % 2, (k / 2) % 2);
            end
        end

        // named corners: R2 borrow, R4 overflow, R10 forced high fix, R11 wrap
        run_vec(3, 8'h00, 8'h00, 0, 0);
        run_vec(0, 8'h7F, 8'h01, 0, 0);
        run_vec(2, 8'h80, 8'h01, 0, 0);
        run_vec(4, 8'h32, 8'h00, 1, 1);
        run_vec(17, 8'h00, 8'hFF, 0, 0);
        run_vec(18, 8'h00, 8'h01, 0, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule